// File: doc/BRIEF.md
# Two-Level Lookup-Table Logic Cell

This block is a small programmable logic cell. Two four-input lookup tables each turn four data pins into one bit. A three-input combining table then takes those two bits plus a direct bypass pin and produces the cell output. Because of the two levels, a function of up to nine inputs can be built, provided it splits into two four-input parts joined by the bypass bit.

The tables start cleared at reset. Software then loads them one bit at a time through a configuration port. Each write names a table, an entry address and a data bit, and it lands on the rising clock edge. After loading, the cell is purely combinational from its data pins to its output. The configuration port has no back-pressure: a write is accepted in every cycle in which the write enable is high, so the port has no ready signal. The data pins are plain levels, not a stream.

Top module: `lcell_top`

## Requirements
- R1: While reset is held and after it is released, every entry of all three tables is 0, so the output is 0 for all 512 input combinations until a write occurs.
- R2: The first four-input table is indexed by `g_in`, with `g_in[3]` as the most significant index bit.
- R3: The second four-input table is indexed by `f_in`, with `f_in[3]` as the most significant index bit.
- R4: The combining table is indexed by {`h_bypass`, first-table bit, second-table bit}, with `h_bypass` as bit 2 and the second-table bit as bit 0. `cell_out` is the entry it selects.
- R5: A write with `cfg_we`=1 updates its entry at the next rising clock edge. Reads are combinational, so `cell_out` shows the new content right after that edge and the old content before it.
- R6: A write changes exactly one entry in exactly one table. All other entries keep their values.
- R7: `cfg_sel` encodes 0 for the first four-input table, 1 for the second and 2 for the combining table. A write with `cfg_sel`=3 changes nothing.
- R8: A write to the combining table uses `cfg_addr[2:0]` and ignores `cfg_addr[3]`.
- R9: With the same four variables A,B,C,D (A the most significant) on both `g_in` and `f_in`, and E on `h_bypass`, the cell can be loaded to produce Z = B·~D·E + ~B·D·~E + A·B·C.
- R10: While `cfg_we`=0, no table changes, whatever the values on `cfg_sel`, `cfg_addr` and `cfg_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Active-low synchronous reset, clears all tables |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Target table: 0 first, 1 second, 2 combining, 3 none |
| cfg_addr | input | 4 | Entry address |
| cfg_bit | input | 1 | Value written to the entry |
| g_in | input | 4 | Index of the first four-input table |
| f_in | input | 4 | Index of the second four-input table |
| h_bypass | input | 1 | Direct bit into the combining table index |
| cell_out | output | 1 | Cell result |

## Verification
The embedded assertions check three things on every cycle: a written entry holds the written bit one cycle later, no table moves without an enable, and the write decoder never enables more than one table and ignores the reserved select. The bench alone can show the index ordering of the three tables, the dropping of address bit 3 for the combining table, and the cleared state after reset. For those it sweeps all 512 input combinations under several table contents and compares each result with a model computed from the requirements. It also shows the realisation of the five-variable target function and the exact cycle at which a write becomes visible.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int unsigned LEAF_K = 4;
  localparam int unsigned JOIN_K = 3;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    TAB_LEAF0 = 2'd0,
    TAB_LEAF1 = 2'd1,
    TAB_JOIN  = 2'd2,
    TAB_NONE  = 2'd3
  } tab_sel_e;
endpackage

// File: rtl/lcell_lut.sv
module lcell_lut #(
  parameter int unsigned K = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [K-1:0] wr_addr,
  input  logic         wr_bit,
  input  logic [K-1:0] rd_idx,
  output logic         rd_bit
);
  localparam int unsigned DEPTH = 1 << K;

  logic [DEPTH-1:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_bit;
    end
  end

  assign rd_bit = mem[rd_idx];

  // R5: a written entry carries the written bit after the edge
  assert_write_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_addr)] == $past(wr_bit));

  // R10: contents hold while no write is enabled
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));
endmodule

// File: rtl/lcell_cfg_decode.sv
module lcell_cfg_decode
  import lcell_pkg::*;
(
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  output logic [1:0]       leaf_we,
  output logic             join_we
);
  tab_sel_e sel;

  always_comb begin
    sel     = tab_sel_e'(cfg_sel);
    leaf_we = '0;
    join_we = 1'b0;
    if (cfg_we) begin
      unique case (sel)
        TAB_LEAF0: leaf_we[0] = 1'b1;
        TAB_LEAF1: leaf_we[1] = 1'b1;
        TAB_JOIN:  join_we    = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [LEAF_K-1:0] cfg_addr,
  input  logic              cfg_bit,
  input  logic [LEAF_K-1:0] g_in,
  input  logic [LEAF_K-1:0] f_in,
  input  logic              h_bypass,
  output logic              cell_out
);
  localparam int unsigned NLEAF = 2;

  logic [1:0]        leaf_we;
  logic              join_we;
  logic [LEAF_K-1:0] leaf_idx [NLEAF];
  logic [NLEAF-1:0]  leaf_bit;
  logic [JOIN_K-1:0] join_idx;

  assign leaf_idx[0] = g_in;
  assign leaf_idx[1] = f_in;

  lcell_cfg_decode u_dec (
    .cfg_we  (cfg_we),
    .cfg_sel (cfg_sel),
    .leaf_we (leaf_we),
    .join_we (join_we)
  );

  for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
    lcell_lut #(.K(LEAF_K)) u_leaf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (leaf_we[i]),
      .wr_addr (cfg_addr),
      .wr_bit  (cfg_bit),
      .rd_idx  (leaf_idx[i]),
      .rd_bit  (leaf_bit[i])
    );
  end

  // index: bypass is MSB, first leaf middle, second leaf LSB
  assign join_idx = {h_bypass, leaf_bit[0], leaf_bit[1]};

  lcell_lut #(.K(JOIN_K)) u_join (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (join_we),
    .wr_addr (cfg_addr[JOIN_K-1:0]),
    .wr_bit  (cfg_bit),
    .rd_idx  (join_idx),
    .rd_bit  (cell_out)
  );

  // R6: at most one table is written per cycle
  assert_single_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({leaf_we, join_we}));

  // R7: the reserved select reaches no table
  assert_reserved_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel == 2'd3) |-> ({leaf_we, join_we} == 3'b000));
endmodule

// File: tb/test_lcell_top.sv
`timescale 1ns/1ps
module test_lcell_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic [3:0] cfg_addr = 4'd0;
  logic       cfg_bit = 1'b0;
  logic [3:0] g_in = 4'd0;
  logic [3:0] f_in = 4'd0;
  logic       h_bypass = 1'b0;
  logic       cell_out;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  logic [15:0] m_g = '0;
  logic [15:0] m_f = '0;
  logic [7:0]  m_h = '0;

  always #5 clk = ~clk;

  lcell_top i_lcell_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_addr(cfg_addr), .cfg_bit(cfg_bit), .g_in(g_in), .f_in(f_in),
    .h_bypass(h_bypass), .cell_out(cell_out)
  );

  function automatic logic model(input logic [3:0] g, input logic [3:0] f, input logic h);
    return m_h[{h, m_g[g], m_f[f]}];
  endfunction

  task automatic check(input string req, input logic exp);
    n_vec++;
    if (cell_out !== exp) begin
      n_bad++;
      $display("FAIL %s g=%h f=%h h=%b actual=%b expected=%b",
               req, g_in, f_in, h_bypass, cell_out, exp);
    end
  endtask

  task automatic sweep(input string req);
    for (int v = 0; v < 512; v++) begin
      {h_bypass, g_in, f_in} = 9'(v);
      #1;
      check(req, model(g_in, f_in, h_bypass));
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [3:0] a, input logic b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_addr = a; cfg_bit = b;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    case (s)
      2'd0: m_g[a] = b;
      2'd1: m_f[a] = b;
      2'd2: m_h[a[2:0]] = b;
      default: ;
    endcase
  endtask

  task automatic load(input logic [15:0] g, input logic [15:0] f, input logic [7:0] h);
    for (int i = 0; i < 16; i++) wr(2'd0, 4'(i), g[i]);
    for (int i = 0; i < 16; i++) wr(2'd1, 4'(i), f[i]);
    for (int i = 0; i < 8; i++)  wr(2'd2, 4'(i), h[i]);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    sweep("R1 in reset");
    rst_n = 1'b1;
    @(posedge clk); #1;
    sweep("R1 after reset");

    // R2 R3 R4: distinct contents, full sweeps
    load(16'hA5C3, 16'h3C96, 8'hE8); sweep("R2 R3 R4 pattern a");
    load(16'h0001, 16'h8000, 8'h96); sweep("R2 R3 R4 pattern b");
    load(16'hFF00, 16'h0F0F, 8'h4B); sweep("R2 R3 R4 pattern c");

    // R6: one entry flipped, rest unchanged
    wr(2'd0, 4'd9, ~m_g[9]); sweep("R6 single leaf entry");
    wr(2'd1, 4'd2, ~m_f[2]); sweep("R6 single second entry");

    // R5: visible exactly at the edge
    g_in = 4'd5; f_in = 4'd6; h_bypass = 1'b1;
    #1;
    begin
      logic [2:0] ji;
      logic old;
      ji  = {h_bypass, m_g[g_in], m_f[f_in]};
      old = m_h[ji];
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd2; cfg_addr = {1'b0, ji}; cfg_bit = ~old;
      #2;
      check("R5 before edge", old);
      @(posedge clk); #1;
      cfg_we = 1'b0;
      m_h[ji] = ~old;
      check("R5 after edge", ~old);
    end

    // R7: reserved select ignored
    for (int i = 0; i < 16; i++) wr(2'd3, 4'(i), ~m_g[i]);
    sweep("R7 reserved select");

    // R10: toggling with enable low
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cfg_sel = 2'(i); cfg_addr = 4'(i * 3); cfg_bit = ~cfg_bit;
    end
    @(posedge clk); #1;
    sweep("R10 enable low");

    // R8: addr[3] dropped for the combining table
    wr(2'd2, 4'b1011, ~m_h[3]);
    sweep("R8 join address");

    // R9: Z = B~DE + ~BD~E + ABC
    begin
      logic [15:0] gg, ff;
      for (int i = 0; i < 16; i++) begin
        logic a, b, c, d;
        {a, b, c, d} = 4'(i);
        gg[i] = (b & ~d) | (a & b & c);
        ff[i] = (~b & d) | (a & b & c);
      end
      load(gg, ff, 8'hCA);
      for (int v = 0; v < 32; v++) begin
        logic a, b, c, d, e;
        {a, b, c, d, e} = 5'(v);
        g_in = {a, b, c, d}; f_in = {a, b, c, d}; h_bypass = e;
        #1;
        check("R9 target function", (b & ~d & e) | (~b & d & ~e) | (a & b & c));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule